// File: doc/BRIEF.md
# One-Cycle 32-bit RISC Core

This block is a small 32-bit processor that finishes each instruction in a single clock cycle. It executes nine instructions: word load, word store, add, subtract, AND, OR, set-on-signed-less-than, branch-if-equal and absolute jump. The core holds the program counter, a 32-entry register file with two read ports and one write port, the ALU, an immediate sign extender, a two-level instruction decoder and the next-PC selector.

Instruction memory and data memory are word arrays inside the core. Both memories use byte addresses, and only the word index selects an entry. A testbench fills both memories through a load port while reset is held, then releases reset and watches three things. These are the program counter, the register-file write port and the data-memory write port. All state changes on the rising clock edge. A register that is read in a cycle can be written at the end of that same cycle.

Decoding works in two levels. First, the 6-bit opcode picks an instruction class. The class sets the datapath steering bits and a 2-bit ALU operation group. Second, the group and the 6-bit funct field give a 3-bit ALU code. The PC has three transitions: sequential (PC+4), branch-taken, and jump. A synchronous reset forces the PC to zero.

Top module: `onecyc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the next `pc_o` is 0. While `rst` is high, `rf_we_o` and `dm_we_o` are 0. After reset is released, execution restarts at address 0.
- R2: Loads, stores, arithmetic instructions and not-taken branches move the PC to PC+4. Unknown opcodes do the same and write nothing.
- R3: An instruction with opcode 000000 is an arithmetic instruction. Its funct field (bits 5-0) selects the operation: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 set-less-than. Set-less-than compares signed values and gives 1 or 0. The result goes to register rd (bits 15-11) on the write port.
- R4: Opcode 100011 is a load. It reads the data word at rs (bits 25-21) plus the sign-extended 16-bit immediate (bits 15-0). It writes that word to register rt (bits 20-16).
- R5: Opcode 101011 is a store. It writes register rt to data memory at rs plus the sign-extended immediate, and it does not write the register file. `dm_addr_o` carries the byte address.
- R6: Opcode 000100 is branch-if-equal. When rs equals rt, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise the next PC is PC+4. Negative offsets branch backward.
- R7: Opcode 000010 is a jump. The next PC is bits 31-28 of PC+4, followed by the 26-bit field in bits 25-0, followed by two zero bits.
- R8: Register 0 always reads as zero. A write aimed at it still appears on the write port, but it leaves the register unchanged.
- R9: The register destination is rd for arithmetic instructions and rt for loads. A value written in one cycle is read by the next instruction.
- R10: When `rst` is high, a rising edge writes `ld_word` at word index `ld_index`. It goes to instruction memory when `ld_imem_we` is high and to data memory when `ld_dmem_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_imem_we | input | 1 | Load one word into instruction memory |
| ld_dmem_we | input | 1 | Load one word into data memory |
| ld_index | input | 32 | Word index for a load-port write |
| ld_word | input | 32 | Data for a load-port write |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | Register write happens at the end of this cycle |
| rf_waddr_o | output | 5 | Register number being written |
| rf_wdata_o | output | 32 | Value being written to the register |
| dm_we_o | output | 1 | Data-memory store happens at the end of this cycle |
| dm_addr_o | output | 32 | Byte address computed by the ALU |
| dm_wdata_o | output | 32 | Store data (register rt) |

## Verification
The program loads a positive and a negative operand and sends them through all five ALU operations. The mixed signs separate signed from unsigned set-less-than and make the AND and OR results different from each other. Stores and loads use both a positive offset and a negative offset from a base register, which exercises the sign extension on the address path. Branches run once not taken, once taken forward over two filler instructions, and finally taken backward onto themselves. A jump also skips fillers, so any filler write that shows up marks a wrong target. A write aimed at register 0 is followed by a read of register 0. A reset in the middle of a run restarts execution and checks that the first load happens again.

// File: rtl/onecyc_pkg.sv
package onecyc_pkg;

    localparam int XLEN = 32;
    localparam int REGS = 32;

    // opcode values
    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_LOAD  = 6'b100011;
    localparam logic [5:0] OP_STORE = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_JUMP  = 6'b000010;

    // funct values for arithmetic instructions
    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_code_e;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10
    } aluop_e;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_ALU,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH,
        CLS_JUMP
    } iclass_e;

    typedef enum logic [1:0] {
        PCS_SEQ,
        PCS_BRANCH,
        PCS_JUMP
    } pc_sel_e;

    typedef struct packed {
        logic   reg_dst;
        logic   alu_src;
        logic   mem_to_reg;
        logic   reg_write;
        logic   mem_read;
        logic   mem_write;
        logic   branch;
        logic   jump;
        aluop_e aluop;
    } ctrl_t;

endpackage

// File: rtl/onecyc_main_dec.sv
module onecyc_main_dec
    import onecyc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);

    iclass_e cls;

    // first level: opcode to instruction class
    always_comb begin
        unique case (opcode)
            OP_RTYPE: cls = CLS_ALU;
            OP_LOAD:  cls = CLS_LOAD;
            OP_STORE: cls = CLS_STORE;
            OP_BEQ:   cls = CLS_BRANCH;
            OP_JUMP:  cls = CLS_JUMP;
            default:  cls = CLS_NONE;
        endcase
    end

    // class to datapath steering; fields the class does not use stay 0
    always_comb begin
        ctrl.reg_dst    = 1'b0;
        ctrl.alu_src    = 1'b0;
        ctrl.mem_to_reg = 1'b0;
        ctrl.reg_write  = 1'b0;
        ctrl.mem_read   = 1'b0;
        ctrl.mem_write  = 1'b0;
        ctrl.branch     = 1'b0;
        ctrl.jump       = 1'b0;
        ctrl.aluop      = AOP_ADD;
        unique case (cls)
            CLS_ALU: begin
                ctrl.reg_dst   = 1'b1;
                ctrl.reg_write = 1'b1;
                ctrl.aluop     = AOP_FUNCT;
            end
            CLS_LOAD: begin
                ctrl.alu_src    = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.reg_write  = 1'b1;
                ctrl.mem_read   = 1'b1;
            end
            CLS_STORE: begin
                ctrl.alu_src   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            CLS_BRANCH: begin
                ctrl.branch = 1'b1;
                ctrl.aluop  = AOP_SUB;
            end
            CLS_JUMP: begin
                ctrl.jump = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/onecyc_alu_dec.sv
module onecyc_alu_dec
    import onecyc_pkg::*;
(
    input  aluop_e     aluop,
    input  logic [5:0] funct,
    output alu_code_e  code
);

    // second level: operation group plus funct to ALU code
    always_comb begin
        unique case (aluop)
            AOP_ADD: code = ALU_ADD;
            AOP_SUB: code = ALU_SUB;
            AOP_FUNCT: begin
                unique case (funct)
                    FN_ADD:  code = ALU_ADD;
                    FN_SUB:  code = ALU_SUB;
                    FN_AND:  code = ALU_AND;
                    FN_OR:   code = ALU_OR;
                    FN_SLT:  code = ALU_SLT;
                    default: code = ALU_ADD;
                endcase
            end
            default: code = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/onecyc_alu.sv
module onecyc_alu
    import onecyc_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_code_e       code,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    always_comb begin
        unique case (code)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/onecyc_regfile.sv
module onecyc_regfile
    import onecyc_pkg::*;
#(
    parameter int NREG = REGS,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic [RAW-1:0]  ra_a,
    input  logic [RAW-1:0]  ra_b,
    output logic [XLEN-1:0] rd_a,
    output logic [XLEN-1:0] rd_b,
    input  logic            we,
    input  logic [RAW-1:0]  wa,
    input  logic [XLEN-1:0] wd
);

    logic [XLEN-1:0] regs [NREG];

    // entry 0 is never written
    always_ff @(posedge clk) begin
        if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

endmodule

// File: rtl/onecyc_ram.sv
module onecyc_ram
    import onecyc_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   raddr,
    output logic [XLEN-1:0] rdata
);

    logic [XLEN-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/onecyc_core.sv
module onecyc_core
    import onecyc_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    parameter int DMEM_DEPTH = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_imem_we,
    input  logic            ld_dmem_we,
    input  logic [31:0]     ld_index,
    input  logic [31:0]     ld_word,
    output logic [XLEN-1:0] pc_o,
    output logic            rf_we_o,
    output logic [4:0]      rf_waddr_o,
    output logic [XLEN-1:0] rf_wdata_o,
    output logic            dm_we_o,
    output logic [XLEN-1:0] dm_addr_o,
    output logic [XLEN-1:0] dm_wdata_o
);

    localparam int IAW = $clog2(IMEM_DEPTH);
    localparam int DAW = $clog2(DMEM_DEPTH);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] j_target;
    pc_sel_e         pc_sel;

    logic [XLEN-1:0] instr;
    ctrl_t           ctrl;
    alu_code_e       alu_code;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] imm_sext;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_res;
    logic            alu_zero;
    logic [XLEN-1:0] dm_rdata;
    logic [XLEN-1:0] load_data;
    logic [4:0]      dest;
    logic [XLEN-1:0] wb_data;
    logic            rf_we;
    logic            dm_we;

    logic            dram_we;
    logic [DAW-1:0]  dram_waddr;
    logic [XLEN-1:0] dram_wdata;

    logic            unused_bits;
    assign unused_bits = ^{ld_index, instr[10:6]};

    // program counter: the only architectural state besides the arrays
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    // fetch
    onecyc_ram #(.DEPTH(IMEM_DEPTH)) u_imem (
        .clk   (clk),
        .we    (ld_imem_we & rst),
        .waddr (ld_index[IAW-1:0]),
        .wdata (ld_word),
        .raddr (pc_q[IAW+1:2]),
        .rdata (instr)
    );

    // decode
    onecyc_main_dec u_main_dec (
        .opcode (instr[31:26]),
        .ctrl   (ctrl)
    );

    onecyc_alu_dec u_alu_dec (
        .aluop (ctrl.aluop),
        .funct (instr[5:0]),
        .code  (alu_code)
    );

    onecyc_regfile #(.NREG(REGS)) u_regs (
        .clk  (clk),
        .ra_a (instr[25:21]),
        .ra_b (instr[20:16]),
        .rd_a (rs_val),
        .rd_b (rt_val),
        .we   (rf_we),
        .wa   (dest),
        .wd   (wb_data)
    );

    assign imm_sext = {{(XLEN-16){instr[15]}}, instr[15:0]};

    // execute
    assign alu_b = ctrl.alu_src ? imm_sext : rt_val;

    onecyc_alu u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .code (alu_code),
        .y    (alu_res),
        .zero (alu_zero)
    );

    // data memory; the load port wins while reset is held
    assign dm_we      = ctrl.mem_write & ~rst;
    assign dram_we    = (ld_dmem_we & rst) | dm_we;
    assign dram_waddr = (ld_dmem_we & rst) ? ld_index[DAW-1:0] : alu_res[DAW+1:2];
    assign dram_wdata = (ld_dmem_we & rst) ? ld_word : rt_val;

    onecyc_ram #(.DEPTH(DMEM_DEPTH)) u_dmem (
        .clk   (clk),
        .we    (dram_we),
        .waddr (dram_waddr),
        .wdata (dram_wdata),
        .raddr (alu_res[DAW+1:2]),
        .rdata (dm_rdata)
    );

    assign load_data = ctrl.mem_read ? dm_rdata : '0;

    // write-back
    assign dest    = ctrl.reg_dst ? instr[15:11] : instr[20:16];
    assign wb_data = ctrl.mem_to_reg ? load_data : alu_res;
    assign rf_we   = ctrl.reg_write & ~rst;

    // next-PC selection
    assign pc_plus4  = pc_q + 32'd4;
    assign br_target = pc_plus4 + {imm_sext[XLEN-3:0], 2'b00};
    assign j_target  = {pc_plus4[XLEN-1:XLEN-4], instr[25:0], 2'b00};

    always_comb begin
        if (ctrl.jump) begin
            pc_sel = PCS_JUMP;
        end else if (ctrl.branch && alu_zero) begin
            pc_sel = PCS_BRANCH;
        end else begin
            pc_sel = PCS_SEQ;
        end
    end

    always_comb begin
        unique case (pc_sel)
            PCS_SEQ:    pc_next = pc_plus4;
            PCS_BRANCH: pc_next = br_target;
            PCS_JUMP:   pc_next = j_target;
            default:    pc_next = pc_plus4;
        endcase
    end

    // observation ports
    assign pc_o       = pc_q;
    assign rf_we_o    = rf_we;
    assign rf_waddr_o = dest;
    assign rf_wdata_o = wb_data;
    assign dm_we_o    = dm_we;
    assign dm_addr_o  = alu_res;
    assign dm_wdata_o = rt_val;

endmodule

// File: rtl/onecyc_chk.sv
module onecyc_chk
    import onecyc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc,
    input logic            rf_we,
    input logic            dm_we,
    input logic [XLEN-1:0] instr,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val
);

    logic [5:0]      op;
    logic [XLEN-1:0] pc_p4;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] j_tgt;
    logic            beq_taken;

    assign op        = instr[31:26];
    assign pc_p4     = pc + 32'd4;
    assign br_tgt    = pc + 32'd4 + {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};
    assign j_tgt     = {pc_p4[XLEN-1:XLEN-4], instr[25:0], 2'b00};
    assign beq_taken = (op == OP_BEQ) && (rs_val == rt_val);

    assert_reset_pc_R1: assert property (@(posedge clk)
        rst |=> (pc == '0));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |-> (!rf_we && !dm_we));

    assert_seq_pc_R2: assert property (@(posedge clk) disable iff (rst)
        ((op != OP_JUMP) && !beq_taken) |=> (pc == $past(pc_p4)));

    assert_store_no_rf_R5: assert property (@(posedge clk) disable iff (rst)
        !(rf_we && dm_we));

    assert_branch_tgt_R6: assert property (@(posedge clk) disable iff (rst)
        beq_taken |=> (pc == $past(br_tgt)));

    assert_jump_tgt_R7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_JUMP) |=> (pc == $past(j_tgt)));

    assert_zero_reg_R8: assert property (@(posedge clk) disable iff (rst)
        (((instr[25:21] == 5'd0) -> (rs_val == '0)) &&
         ((instr[20:16] == 5'd0) -> (rt_val == '0))));

    assert_pc_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        (pc[1:0] == 2'b00));

endmodule

bind onecyc_core onecyc_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .pc     (pc_o),
    .rf_we  (rf_we_o),
    .dm_we  (dm_we_o),
    .instr  (instr),
    .rs_val (rs_val),
    .rt_val (rt_val)
);

// File: tb/test_onecyc_core.sv
module test_onecyc_core;

    // one time unit is taken as 1 ns: 8-unit period, 125 MHz
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_imem_we = 1'b0;
    logic        ld_dmem_we = 1'b0;
    logic [31:0] ld_index = '0;
    logic [31:0] ld_word = '0;
    logic [31:0] pc_o;
    logic        rf_we_o;
    logic [4:0]  rf_waddr_o;
    logic [31:0] rf_wdata_o;
    logic        dm_we_o;
    logic [31:0] dm_addr_o;
    logic [31:0] dm_wdata_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    onecyc_core i_onecyc_core (
        .clk        (clk),
        .rst        (rst),
        .ld_imem_we (ld_imem_we),
        .ld_dmem_we (ld_dmem_we),
        .ld_index   (ld_index),
        .ld_word    (ld_word),
        .pc_o       (pc_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o),
        .dm_we_o    (dm_we_o),
        .dm_addr_o  (dm_addr_o),
        .dm_wdata_o (dm_wdata_o)
    );

    typedef struct packed {
        logic [31:0] pc;
        logic        rfwe;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic        dmwe;
        logic [31:0] da;
        logic [31:0] dd;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 22;
    localparam int NPROG = 26;

    // expected outputs per cycle after reset release
    localparam vec_t VEC [NVEC] = '{
        '{32'd0,   1'b1, 5'd1,  32'd5,        1'b0, 32'd0,  32'd0,        4'd10}, // R10 preloaded data, R4
        '{32'd4,   1'b1, 5'd2,  32'hFFFFFFFD, 1'b0, 32'd0,  32'd0,        4'd2},  // R2 sequential, R4
        '{32'd8,   1'b1, 5'd3,  32'd2,        1'b0, 32'd0,  32'd0,        4'd9},  // R9 add uses fresh r1,r2
        '{32'd12,  1'b1, 5'd4,  32'd8,        1'b0, 32'd0,  32'd0,        4'd3},  // R3 sub
        '{32'd16,  1'b1, 5'd5,  32'd5,        1'b0, 32'd0,  32'd0,        4'd3},  // R3 and
        '{32'd20,  1'b1, 5'd6,  32'hFFFFFFFD, 1'b0, 32'd0,  32'd0,        4'd3},  // R3 or
        '{32'd24,  1'b1, 5'd7,  32'd1,        1'b0, 32'd0,  32'd0,        4'd3},  // R3 slt negative<positive
        '{32'd28,  1'b1, 5'd8,  32'd0,        1'b0, 32'd0,  32'd0,        4'd3},  // R3 slt positive<negative
        '{32'd32,  1'b0, 5'd0,  32'd0,        1'b1, 32'd12, 32'd2,        4'd5},  // R5 store
        '{32'd36,  1'b1, 5'd9,  32'd2,        1'b0, 32'd0,  32'd0,        4'd4},  // R4 load back stored word
        '{32'd40,  1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0,        4'd6},  // R6 beq not taken
        '{32'd44,  1'b1, 5'd0,  32'd10,       1'b0, 32'd0,  32'd0,        4'd8},  // R8 write aimed at r0
        '{32'd48,  1'b1, 5'd10, 32'd0,        1'b0, 32'd0,  32'd0,        4'd8},  // R8 r0 still zero
        '{32'd52,  1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0,        4'd6},  // R6 beq taken forward
        '{32'd64,  1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0,        4'd6},  // R6 landed at target
        '{32'd80,  1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0,        4'd7},  // R7 landed at jump target
        '{32'd88,  1'b1, 5'd13, 32'h00000100, 1'b0, 32'd0,  32'd0,        4'd4},  // R4 base word
        '{32'd92,  1'b0, 5'd0,  32'd0,        1'b1, 32'd16, 32'hFFFFFFFD, 4'd5},  // R5 negative offset
        '{32'd96,  1'b1, 5'd14, 32'hFFFFFFFD, 1'b0, 32'd0,  32'd0,        4'd5},  // R5 stored word read back
        '{32'd100, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0,        4'd6},  // R6 backward self branch
        '{32'd100, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0,        4'd6},  // R6
        '{32'd100, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0,        4'd6}   // R6
    };

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    function automatic logic [31:0] enc_j(input int widx);
        return {6'b000010, widx[25:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_word(input bit to_imem, input int idx, input logic [31:0] w);
        ld_imem_we = to_imem;
        ld_dmem_we = !to_imem;
        ld_index   = idx;
        ld_word    = w;
        @(negedge clk);
        ld_imem_we = 1'b0;
        ld_dmem_we = 1'b0;
    endtask

    localparam logic [5:0] LW  = 6'b100011;
    localparam logic [5:0] SW  = 6'b101011;
    localparam logic [5:0] BEQ = 6'b000100;
    localparam logic [5:0] ADD = 6'b100000;
    localparam logic [5:0] SUB = 6'b100010;
    localparam logic [5:0] AND = 6'b100100;
    localparam logic [5:0] OR  = 6'b100101;
    localparam logic [5:0] SLT = 6'b101010;

    logic [31:0] prog [NPROG];

    initial begin
        prog[0]  = enc_i(LW, 0, 1, 16'd0);
        prog[1]  = enc_i(LW, 0, 2, 16'd4);
        prog[2]  = enc_r(1, 2, 3, ADD);
        prog[3]  = enc_r(1, 2, 4, SUB);
        prog[4]  = enc_r(1, 2, 5, AND);
        prog[5]  = enc_r(1, 2, 6, OR);
        prog[6]  = enc_r(2, 1, 7, SLT);
        prog[7]  = enc_r(1, 2, 8, SLT);
        prog[8]  = enc_i(SW, 0, 3, 16'd12);
        prog[9]  = enc_i(LW, 0, 9, 16'd12);
        prog[10] = enc_i(BEQ, 1, 2, 16'd5);
        prog[11] = enc_r(1, 1, 0, ADD);
        prog[12] = enc_r(0, 0, 10, ADD);
        prog[13] = enc_i(BEQ, 3, 9, 16'd2);
        prog[14] = enc_r(1, 1, 11, ADD);
        prog[15] = enc_r(1, 1, 11, ADD);
        prog[16] = enc_j(20);
        prog[17] = enc_r(1, 1, 12, ADD);
        prog[18] = enc_r(1, 1, 12, ADD);
        prog[19] = enc_r(1, 1, 12, ADD);
        prog[20] = enc_i(BEQ, 0, 0, 16'd1);
        prog[21] = enc_r(1, 1, 15, ADD);
        prog[22] = enc_i(LW, 0, 13, 16'd8);
        prog[23] = enc_i(SW, 13, 2, 16'hFF10);
        prog[24] = enc_i(LW, 0, 14, 16'd16);
        prog[25] = enc_i(BEQ, 0, 0, 16'hFFFF);

        @(negedge clk);
        for (int k = 0; k < NPROG; k++) load_word(1'b1, k, prog[k]);
        load_word(1'b0, 0, 32'd5);
        load_word(1'b0, 1, 32'hFFFFFFFD);
        load_word(1'b0, 2, 32'h00000100);

        // reset state, R1: the instruction at address 0 is a load, yet no write shows
        #1;
        chk("R1 reset pc", pc_o, 32'd0);
        chk("R1 reset rf_we", {31'd0, rf_we_o}, 32'd0);
        chk("R1 reset dm_we", {31'd0, dm_we_o}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            #1;
            chk($sformatf("R%0d vec %0d pc", VEC[i].req, i), pc_o, VEC[i].pc);
            chk($sformatf("R%0d vec %0d rf_we", VEC[i].req, i), {31'd0, rf_we_o}, {31'd0, VEC[i].rfwe});
            chk($sformatf("R%0d vec %0d dm_we", VEC[i].req, i), {31'd0, dm_we_o}, {31'd0, VEC[i].dmwe});
            if (VEC[i].rfwe) begin
                chk($sformatf("R%0d vec %0d rf_waddr", VEC[i].req, i), {27'd0, rf_waddr_o}, {27'd0, VEC[i].wa});
                chk($sformatf("R%0d vec %0d rf_wdata", VEC[i].req, i), rf_wdata_o, VEC[i].wd);
            end
            if (VEC[i].dmwe) begin
                chk($sformatf("R%0d vec %0d dm_addr", VEC[i].req, i), dm_addr_o, VEC[i].da);
                chk($sformatf("R%0d vec %0d dm_wdata", VEC[i].req, i), dm_wdata_o, VEC[i].dd);
            end
            @(negedge clk);
        end

        // R1: reset in the middle of a run, then restart from address 0
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 mid-run reset pc", pc_o, 32'd0);
        chk("R1 mid-run reset rf_we", {31'd0, rf_we_o}, 32'd0);
        rst = 1'b0;
        #1;
        chk("R1 restart rf_we", {31'd0, rf_we_o}, 32'd1);
        chk("R1 restart load data", rf_wdata_o, 32'd5);
        @(negedge clk);
        #1;
        chk("R2 restart second pc", pc_o, 32'd4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            nfail++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule